// File: doc/BRIEF.md
# SPI Mode-3 Flash Command Master

This block runs single command transactions against one serial flash device over a four-wire SPI link in mode 3. A host hands it a request made of an opcode byte, up to a few payload bytes to send after the opcode, and a count of bytes to read back. The block frames the transaction with an active-low chip select. It shifts the opcode and payload out MSB first, then keeps clocking while it collects the reply. Each received byte is presented on a one-cycle valid strobe.

The serial clock comes from the system clock through an even divider and rests high between transactions. Chip select only moves while the serial clock is high. There is one half-period of setup before the first falling edge and one half-period of hold after the last rising edge. At least one full serial period passes with chip select high before the next transaction can begin. A typical use is polling a flash status register with opcode 0xD7. The device keeps MISO high while the opcode is shifted in and then returns its status byte.

Top module: `spi_cmd_master`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, `cs_n`, `sck` and `mosi` are 1, and `busy`, `done`, `rx_valid` and `req_ack` are 0.
- R2: `sck` idles high. During a transaction each high and each low phase of `sck` lasts exactly CLK_DIV/2 system clocks. CLK_DIV is even and at least 4.
- R3: `cs_n` changes only while `sck` is high and was high in the previous cycle. The first falling edge of `sck` comes exactly CLK_DIV/2 clocks after `cs_n` falls. `cs_n` rises at least CLK_DIV/2 clocks after the last rising edge of `sck`.
- R4: `mosi` changes during a transaction only in the cycle in which `sck` falls. The transmitted stream is MSB first, in this order: the opcode, then `req_tx_len` payload bytes from `req_tx_data` (byte k at bits [8k+7:8k], k = 0 first), then 0xFF for every receive byte.
- R5: `miso` is sampled on the rising edge of `sck`, and bytes are assembled MSB first. Bits clocked during the opcode and payload bytes are discarded. Exactly `req_rx_len` bytes are returned, each as a one-cycle `rx_valid` pulse with the byte on `rx_data`, in the cycle `sck` rises for its last bit.
- R6: A request (`req_valid` high) is accepted only when the block is idle. Acceptance gives a one-cycle `req_ack` in the same cycle in which `busy` rises and `cs_n` falls. A request raised and dropped while busy is ignored.
- R7: `busy` is high from acceptance until `cs_n` returns high. `done` pulses for one cycle, once per transaction, in the cycle `cs_n` rises, with `busy` already low.
- R8: Between the rise of `cs_n` and its next fall, at least CLK_DIV system clocks pass, even with `req_valid` held high.
- R9: `cs_n` stays low for the whole transaction, which carries exactly 8 × (1 + `req_tx_len` + `req_rx_len`) rising `sck` edges. `sck` toggles only while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction request |
| req_op | input | 8 | Opcode byte |
| req_tx_len | input | $clog2(TX_DEPTH+1) | Payload bytes to send after the opcode |
| req_tx_data | input | 8*TX_DEPTH | Payload bytes, byte 0 in the low bits |
| req_rx_len | input | RX_LEN_W | Bytes to read after the payload |
| req_ack | output | 1 | One-cycle request acceptance pulse |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
Two events can land in the same cycle: a pending request, and the end of the chip-select-high gap that follows a transaction. The bench provokes this by holding `req_valid` high straight through a transaction's `done`. The second acceptance then lands on the first idle cycle after the gap. The check is that exactly one extra acknowledge arrives, no earlier than CLK_DIV clocks after `done`, and that the second transaction returns correct status bytes. A separate case pulses `req_valid` in the middle of a transaction and confirms that no further acknowledge appears and that chip select stays high afterwards.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int CLK_DIV  = 32,
  parameter int TX_DEPTH = 4,
  parameter int RX_LEN_W = 8,
  localparam int TXL_W   = $clog2(TX_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [7:0]            req_op,
  input  logic [TXL_W-1:0]      req_tx_len,
  input  logic [TX_DEPTH*8-1:0] req_tx_data,
  input  logic [RX_LEN_W-1:0]   req_rx_len,
  output logic                  req_ack,
  output logic                  busy,
  output logic                  done,
  output logic                  rx_valid,
  output logic [7:0]            rx_data,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HCW  = $clog2(CLK_DIV);
  localparam int IDXW = RX_LEN_W + 2;
  localparam int TXB  = TX_DEPTH * 8 + 8;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_GAP} st_t;

  st_t              state;
  logic [HCW-1:0]   hc;
  logic [2:0]       bit_i;
  logic [IDXW-1:0]  byte_i, last_i;
  logic [TXL_W-1:0] txn;
  logic [TXB-1:0]   tx_buf;
  logic [7:0]       sh;
  logic [6:0]       rsh;
  logic             fin;

  wire half_end = (hc == HCW'(HALF - 1));
  wire gap_end  = (hc == HCW'(CLK_DIV - 1));
  wire rx_phase = (byte_i > IDXW'(txn));

  assign busy = (state == S_SETUP) || (state == S_LOW) || (state == S_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hc       <= '0;
      bit_i    <= '0;
      byte_i   <= '0;
      last_i   <= '0;
      txn      <= '0;
      tx_buf   <= '1;
      sh       <= '1;
      rsh      <= '0;
      fin      <= 1'b0;
      sck      <= 1'b1;
      cs_n     <= 1'b1;
      mosi     <= 1'b1;
      req_ack  <= 1'b0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      req_ack  <= 1'b0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          hc <= '0;
          if (req_valid) begin
            req_ack <= 1'b1;
            cs_n    <= 1'b0;
            sh      <= req_op;
            tx_buf  <= {8'hFF, req_tx_data};
            txn     <= req_tx_len;
            last_i  <= IDXW'(req_tx_len) + IDXW'(req_rx_len);
            byte_i  <= '0;
            bit_i   <= '0;
            fin     <= 1'b0;
            state   <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (half_end) begin
            hc    <= '0;
            sck   <= 1'b0;
            mosi  <= sh[7];
            sh    <= {sh[6:0], 1'b1};
            state <= S_LOW;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        S_LOW: begin
          if (half_end) begin
            hc    <= '0;
            sck   <= 1'b1;
            rsh   <= {rsh[5:0], miso};
            bit_i <= bit_i + 1'b1;
            fin   <= (bit_i == 3'd7) && (byte_i == last_i);
            if (bit_i == 3'd7) begin
              if (rx_phase) begin
                rx_valid <= 1'b1;
                rx_data  <= {rsh, miso};
              end
              if (byte_i < IDXW'(txn)) begin
                sh     <= tx_buf[7:0];
                tx_buf <= {8'hFF, tx_buf[TXB-1:8]};
              end else begin
                sh <= 8'hFF;
              end
              byte_i <= byte_i + 1'b1;
            end
            state <= S_HIGH;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        S_HIGH: begin
          if (half_end) begin
            hc <= '0;
            if (fin) begin
              cs_n  <= 1'b1;
              done  <= 1'b1;
              state <= S_GAP;
            end else begin
              sck   <= 1'b0;
              mosi  <= sh[7];
              sh    <= {sh[6:0], 1'b1};
              state <= S_LOW;
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        S_GAP: begin
          if (gap_end) begin
            hc    <= '0;
            state <= S_IDLE;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  cs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> (sck && $past(sck)));

  // R9
  sck_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> (!cs_n && !$past(cs_n)));

  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cs_n) && !busy));

  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (!$past(busy) && $past(req_valid) && busy));

  // R5
  rxv_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($rose(sck) && !cs_n));

  // R4
  mosi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (mosi != $past(mosi))) |-> $fell(sck));
endmodule

// File: tb/spi_cmd_master_test.sv
module spi_cmd_master_test;
  localparam int CLK_DIV  = 8;
  localparam int HALF     = CLK_DIV / 2;
  localparam int TX_DEPTH = 4;
  localparam int RX_LEN_W = 8;
  localparam logic [7:0] STATUS = 8'h9A;
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {8'hD7, 3'd0, 32'h00000000, 8'd1},
    {8'hD7, 3'd0, 32'h00000000, 8'd3},
    {8'h9F, 3'd0, 32'h00000000, 8'd2},
    {8'h0B, 3'd3, 32'h00332211, 8'd2},
    {8'h82, 3'd4, 32'h44434241, 8'd0},
    {8'h06, 3'd0, 32'h00000000, 8'd0}
  };

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [7:0] req_op = 0;
  logic [2:0] req_tx_len = 0;
  logic [31:0] req_tx_data = 0;
  logic [7:0] req_rx_len = 0;
  logic req_ack, busy, done, rx_valid, sck, cs_n, mosi;
  logic [7:0] rx_data;
  logic miso = 1'b1;

  always #10 clk = ~clk;

  spi_cmd_master #(.CLK_DIV(CLK_DIV), .TX_DEPTH(TX_DEPTH), .RX_LEN_W(RX_LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tx_len(req_tx_len), .req_tx_data(req_tx_data), .req_rx_len(req_rx_len),
    .req_ack(req_ack), .busy(busy), .done(done), .rx_valid(rx_valid),
    .rx_data(rx_data), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  // behavioural flash slave
  int s_bits = 0, mcount = 0, s_nb = 0;
  logic [7:0] mlog [16];
  logic [7:0] s_sh = 0, s_cmd = 0, s_resp = 8'hFF;
  initial begin
    logic pcs, psck;
    pcs = 1; psck = 1;
    forever begin
      @(cs_n or sck);
      if (cs_n != pcs) begin
        if (!cs_n) begin s_bits = 0; mcount = 0; s_nb = 0; end
        miso = 1'b1;
      end
      if (!cs_n && sck && !psck) begin
        s_sh = {s_sh[6:0], mosi};
        s_bits++;
        if (s_bits % 8 == 0) begin
          if (mcount < 16) mlog[mcount] = s_sh;
          mcount++;
          if (s_bits == 8) s_cmd = s_sh;
        end
      end
      if (!cs_n && !sck && psck && s_bits >= 8) begin
        if (s_bits % 8 == 0) begin
          s_resp = (s_cmd == 8'hD7) ? STATUS : 8'hA0 + 8'(s_nb);
          s_nb++;
        end
        miso = s_resp[7];
        s_resp = {s_resp[6:0], 1'b1};
      end
      pcs = cs_n; psck = sck;
    end
  end

  // port monitor
  int cyc = 0, t_sck = 0, t_sckr = 0, t_csf = 0, t_csr = 0;
  int bad_half = 0, bad_setup = 0, bad_hold = 0, bad_gap = 0, bad_cs = 0, bad_mosi = 0, bad_done = 0;
  int n_done = 0, n_ack = 0, rxcount = 0, t_done = 0, t_ack = 0;
  logic [7:0] rxlog [64];
  logic pcs_m = 1, psck_m = 1, pmosi_m = 1, first_fall = 0, seen_rise = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n != pcs_m) begin
        if (!sck || !psck_m) bad_cs++;
        if (!cs_n) begin
          if (seen_rise && (cyc - t_csr) < CLK_DIV) bad_gap++;
          t_csf = cyc; first_fall = 1;
        end else begin
          if ((cyc - t_sckr) < HALF) bad_hold++;
          t_csr = cyc; seen_rise = 1;
        end
      end
      if (sck != psck_m) begin
        if (!sck && first_fall) begin
          if ((cyc - t_csf) != HALF) bad_setup++;
          first_fall = 0;
        end else if ((cyc - t_sck) != HALF) bad_half++;
        t_sck = cyc;
        if (sck) t_sckr = cyc;
      end
      if (!cs_n && (mosi != pmosi_m) && !(psck_m && !sck)) bad_mosi++;
      if (done) begin
        n_done++; t_done = cyc;
        if (busy || !cs_n || pcs_m) bad_done++;
      end
      if (req_ack) begin n_ack++; t_ack = cyc; end
      if (rx_valid) begin
        if (rxcount < 64) rxlog[rxcount] = rx_data;
        rxcount++;
      end
    end
    pcs_m = cs_n; psck_m = sck; pmosi_m = mosi;
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(input int a0);
    int n = 0;
    while (n_ack == a0 && n < 5000) begin @(negedge clk); n++; end
    chk(n_ack > a0, "R6 request acknowledged", n_ack, a0 + 1);
  endtask

  task automatic wait_done(input int d0);
    int n = 0;
    while (n_done == d0 && n < 20000) begin @(negedge clk); n++; end
    chk(n_done == d0 + 1, "R7 one done per transaction", n_done, d0 + 1);
  endtask

  task automatic run_txn(input logic [50:0] v);
    logic [7:0] op, rl; logic [2:0] tl; logic [31:0] dat;
    int a0, d0, r0;
    logic [7:0] e;
    op = v[50:43]; tl = v[42:40]; dat = v[39:8]; rl = v[7:0];
    a0 = n_ack; d0 = n_done; r0 = rxcount;
    @(negedge clk);
    req_op = op; req_tx_len = tl; req_tx_data = dat; req_rx_len = rl; req_valid = 1;
    wait_ack(a0);
    req_valid = 0;
    chk(busy && !cs_n, "R7 busy and cs low after accept", {busy, cs_n}, 2'b10);
    wait_done(d0);
    @(negedge clk);
    chk(!busy && cs_n, "R7 idle after done", {busy, cs_n}, 2'b01);
    chk(rxcount - r0 == int'(rl), "R5 rx byte count", rxcount - r0, rl);
    for (int j = 0; j < int'(rl); j++) begin
      e = (op == 8'hD7) ? STATUS : 8'hA0 + 8'(int'(tl) + j);
      chk(rxlog[r0 + j] == e, "R5 rx byte", rxlog[r0 + j], e);
    end
    chk(s_bits == 8 * (1 + int'(tl) + int'(rl)), "R9 sck rising edges", s_bits, 8 * (1 + int'(tl) + int'(rl)));
    chk(mcount == 1 + int'(tl) + int'(rl), "R4 mosi byte count", mcount, 1 + int'(tl) + int'(rl));
    chk(mlog[0] == op, "R4 opcode first MSB first", mlog[0], op);
    for (int k = 0; k < int'(tl); k++)
      chk(mlog[1 + k] == dat[8*k +: 8], "R4 payload byte order", mlog[1 + k], dat[8*k +: 8]);
    for (int j = 0; j < int'(rl) && 1 + int'(tl) + j < 16; j++)
      chk(mlog[1 + int'(tl) + j] == 8'hFF, "R4 ones during receive", mlog[1 + int'(tl) + j], 8'hFF);
  endtask

  initial begin
    int a0, d0, r0, tgap;
    repeat (5) @(negedge clk);
    // R1 during reset
    chk(cs_n && sck && mosi, "R1 lines high in reset", {cs_n, sck, mosi}, 3'b111);
    chk(!busy && !done && !rx_valid && !req_ack, "R1 strobes low in reset",
        {busy, done, rx_valid, req_ack}, 4'b0000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cs_n && sck && !busy, "R1 idle after reset", {cs_n, sck, busy}, 3'b110);

    for (int i = 0; i < NV; i++) run_txn(VEC[i]);

    // R6: request pulsed while busy is ignored
    a0 = n_ack; d0 = n_done;
    @(negedge clk);
    req_op = 8'hD7; req_tx_len = 0; req_rx_len = 2; req_valid = 1;
    wait_ack(a0);
    req_valid = 0;
    repeat (20) @(negedge clk);
    req_op = 8'h9F; req_valid = 1;
    repeat (10) @(negedge clk);
    req_valid = 0;
    wait_done(d0);
    repeat (3 * CLK_DIV) @(negedge clk);
    chk(n_ack == a0 + 1, "R6 busy request ignored", n_ack, a0 + 1);
    chk(cs_n && !busy, "R6 no extra transaction", {cs_n, busy}, 2'b10);

    // R8: request held across done meets the end of the gap
    a0 = n_ack; d0 = n_done; r0 = rxcount;
    req_op = 8'hD7; req_tx_len = 0; req_rx_len = 1; req_valid = 1;
    wait_ack(a0);
    wait_done(d0);
    tgap = t_done;
    wait_ack(a0 + 1);
    req_valid = 0;
    chk(t_ack - tgap >= CLK_DIV, "R8 gap before next select", t_ack - tgap, CLK_DIV);
    chk(n_ack == a0 + 2, "R8 exactly one re-acceptance", n_ack, a0 + 2);
    wait_done(d0 + 1);
    repeat (2) @(negedge clk);
    chk(rxcount - r0 == 2 && rxlog[r0 + 1] == STATUS, "R8 second status read", rxlog[r0 + 1], STATUS);

    chk(bad_half == 0, "R2 sck half period", bad_half, 0);
    chk(bad_setup == 0, "R3 select setup", bad_setup, 0);
    chk(bad_hold == 0, "R3 select hold", bad_hold, 0);
    chk(bad_cs == 0, "R3 select moves with sck high", bad_cs, 0);
    chk(bad_gap == 0, "R8 select high time", bad_gap, 0);
    chk(bad_mosi == 0, "R4 mosi on falling edge", bad_mosi, 0);
    chk(bad_done == 0, "R7 done with select rise", bad_done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule